// File: doc/BRIEF.md
# MDIO Management Master

This block gives a host a set of 32-bit memory-mapped registers for reading and writing PHY registers over the two-wire management bus. It divides the system clock down to produce the management clock (MDC). It sends Clause 22 frames most significant bit first. On a read it releases the data line at turnaround and shifts in the 16-bit reply. An input pin selects the byte order the host sees. Every 32-bit word the host writes or reads is byte-swapped when big-endian order is selected.

Software starts a read by writing the PHY and register numbers to the control register with its read flag set. It then polls the busy flag until it clears, checks the read-error flag, and takes the reply from the data register. A write takes two register writes. A control write without the read flag only stores the address, and the data-register write that follows sends the frame.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads as zero and the MDIO output enable is low.
- R2: MDC runs with a period of 2*DIV_HALF system clocks. The MDIO output changes only on the MDC falling edge, so it is stable at every MDC rising edge.
- R3: A control-register write (offset 0x34) with bit 15 clear stores the PHY address (bits 9:5) and the register address (bits 4:0), starts no frame and leaves busy at 0.
- R4: A data-register write (offset 0x38) sends a 64-bit frame made of 32 ones, then 01, then opcode 01, then PHY[4:0], then REG[4:0], then turnaround 10, then the 16 data bits. The output enable is high for all 64 bits.
- R5: A control-register write with bit 15 set sends a read frame. Its first 46 bits are 32 ones, then 01, then opcode 10, then PHY[4:0], then REG[4:0].
- R6: In a read frame the output enable is low for the last 18 bits. The 16 bits sampled on the last 16 MDC rising edges appear in bits 15:0 of the data register once busy clears.
- R7: Bit 31 of the configuration register (offset 0x30) reads 1 from the clock cycle after a launching write until the last frame bit has been sent, and then returns to 0.
- R8: Bit 1 of the configuration register is set when the PHY drives the second turnaround bit high during a read. The next accepted read launch clears it.
- R9: While busy is 1, writes to the control and data registers are ignored. Their contents do not change and no further frame is sent.
- R10: Bit 6 of the configuration register can be written and read back, and the other configuration bits cannot be written. The address register (offset 0x3c) stores and returns all 32 bits. Frames stay in Clause 22 format.
- R11: When big_endian is 1, the host bus data is byte-swapped in both directions on every register access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_endian | input | 1 | 1 selects byte-swapped register access |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
The busy flag is due one clock after the edge that accepts a launching write. The bench therefore reads it at the falling clock edge that ends the write task. Frame bits are due at the MDC rising edge and are recorded there, at least DIV_HALF system clocks after the falling edge that set them. Captured data and the read-error flag are due at the edge that clears busy, so the bench compares them only after a poll first sees busy at 0. At that moment the bench also confirms that all 64 frame bits have already been observed on the wire.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 64;
  localparam int HDR_BITS   = 46;               // bits driven before turnaround in a read
  localparam int TA2_IDX    = HDR_BITS + 1;     // second turnaround bit
  localparam int DATA_IDX   = HDR_BITS + 2;     // first reply bit

  localparam logic [7:0] OFS_CFG  = 8'h30;
  localparam logic [7:0] OFS_CTL  = 8'h34;
  localparam logic [7:0] OFS_DATA = 8'h38;
  localparam logic [7:0] OFS_ADDR = 8'h3c;

  localparam int CFG_BUSY_BIT = 31;
  localparam int CFG_C45_BIT  = 6;
  localparam int CFG_RERR_BIT = 1;
  localparam int CTL_RD_BIT   = 15;

  typedef enum logic [1:0] {
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10
  } mdio_opc_e;

  function automatic logic [31:0] swap_bytes(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [63:0] c22_frame(input logic rd, input logic [4:0] phy,
                                            input logic [4:0] regad, input logic [15:0] data);
    mdio_opc_e opc;
    opc = rd ? OPC_READ : OPC_WRITE;
    return {32'hFFFF_FFFF, 2'b01, opc, phy, regad, rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : data};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic fall_tick,
  output logic rise_tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          term;

  assign term = (cnt_q == CW'(DIV_HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc       = mdc_q;
  assign fall_tick = term & mdc_q;
  assign rise_tick = term & ~mdc_q;

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fall_tick,
  input  logic        rise_tick,
  input  logic        go,
  input  logic        go_read,
  input  logic [4:0]  go_phy,
  input  logic [4:0]  go_reg,
  input  logic [15:0] go_data,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        read_turn,
  output logic        frame_done,
  output logic        rd_fail,
  output logic [15:0] rd_data
);
  logic        pend_q, onwire_q, is_rd_q, fail_q;
  logic [5:0]  idx_q;
  logic [63:0] frame_q;
  logic [15:0] shin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      onwire_q <= 1'b0;
      is_rd_q  <= 1'b0;
      fail_q   <= 1'b0;
      idx_q    <= '0;
      frame_q  <= '0;
      shin_q   <= '0;
    end else begin
      if (go) begin
        pend_q  <= 1'b1;
        is_rd_q <= go_read;
        frame_q <= c22_frame(go_read, go_phy, go_reg, go_data);
      end
      if (fall_tick) begin
        if (onwire_q) begin
          if (idx_q == 6'(FRAME_BITS - 1)) onwire_q <= 1'b0;
          else                             idx_q    <= idx_q + 1'b1;
        end else if (pend_q) begin
          pend_q   <= 1'b0;
          onwire_q <= 1'b1;
          idx_q    <= '0;
          fail_q   <= 1'b0;
        end
      end
      if (rise_tick && onwire_q && is_rd_q) begin
        if (idx_q == 6'(TA2_IDX)) fail_q <= mdio_i;
        if (idx_q >= 6'(DATA_IDX)) shin_q <= {shin_q[14:0], mdio_i};
      end
    end
  end

  assign read_turn  = onwire_q && is_rd_q && (idx_q >= 6'(HDR_BITS));
  assign mdio_oe    = onwire_q && !read_turn;
  assign mdio_o     = onwire_q ? frame_q[6'(FRAME_BITS - 1) - idx_q] : 1'b1;
  assign frame_done = fall_tick && onwire_q && (idx_q == 6'(FRAME_BITS - 1));
  assign rd_fail    = fail_q;
  assign rd_data    = shin_q;

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              frame_done,
  input  logic              rd_fail,
  input  logic [15:0]       rd_data,
  output logic              launch,
  output logic              go_read,
  output logic [4:0]        go_phy,
  output logic [4:0]        go_reg,
  output logic [15:0]       go_data,
  output logic              busy,
  output logic              wr_blocked,
  output logic [15:0]       ctl_word
);
  logic        busy_q, c45_q, rerr_q, cur_rd_q;
  logic [15:0] ctl_q, data_q;
  logic [31:0] addr_q;
  logic        sel_cfg, sel_ctl, sel_data, sel_addr, ctl_ok, data_ok;

  assign sel_cfg  = bus_wr && (bus_addr == ADDR_W'(OFS_CFG));
  assign sel_ctl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTL));
  assign sel_data = bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
  assign sel_addr = bus_wr && (bus_addr == ADDR_W'(OFS_ADDR));
  assign ctl_ok   = sel_ctl && !busy_q;
  assign data_ok  = sel_data && !busy_q;

  assign go_read    = ctl_ok && wdata[CTL_RD_BIT];
  assign launch     = go_read || data_ok;
  assign go_phy     = go_read ? wdata[9:5] : ctl_q[9:5];
  assign go_reg     = go_read ? wdata[4:0] : ctl_q[4:0];
  assign go_data    = wdata[15:0];
  assign wr_blocked = (sel_ctl || sel_data) && busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      c45_q    <= 1'b0;
      rerr_q   <= 1'b0;
      cur_rd_q <= 1'b0;
      ctl_q    <= '0;
      data_q   <= '0;
      addr_q   <= '0;
    end else begin
      if (sel_cfg)  c45_q  <= wdata[CFG_C45_BIT];
      if (sel_addr) addr_q <= wdata;
      if (ctl_ok)   ctl_q  <= wdata[15:0];
      if (data_ok)  data_q <= wdata[15:0];
      if (go_read)  rerr_q <= 1'b0;
      if (launch) begin
        busy_q   <= 1'b1;
        cur_rd_q <= go_read;
      end else if (frame_done) begin
        busy_q <= 1'b0;
        if (cur_rd_q) begin
          data_q <= rd_data;
          rerr_q <= rd_fail;
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (bus_addr)
      ADDR_W'(OFS_CFG): begin
        rdata[CFG_BUSY_BIT] = busy_q;
        rdata[CFG_C45_BIT]  = c45_q;
        rdata[CFG_RERR_BIT] = rerr_q;
      end
      ADDR_W'(OFS_CTL):  rdata = {16'h0, ctl_q};
      ADDR_W'(OFS_DATA): rdata = {16'h0, data_q};
      ADDR_W'(OFS_ADDR): rdata = addr_q;
      default:           rdata = '0;
    endcase
  end

  assign busy     = busy_q;
  assign ctl_word = ctl_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [31:0] wdata_n, rdata_n;
  logic        fall_tick, rise_tick, launch, go_read, busy, wr_blocked;
  logic        frame_done, read_turn, rd_fail;
  logic [4:0]  go_phy, go_reg;
  logic [15:0] go_data, rd_data, ctl_word;

  assign wdata_n   = big_endian ? swap_bytes(bus_wdata) : bus_wdata;
  assign bus_rdata = big_endian ? swap_bytes(rdata_n) : rdata_n;

  mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .fall_tick(fall_tick), .rise_tick(rise_tick)
  );

  mdio_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .wdata(wdata_n),
    .rdata(rdata_n), .frame_done(frame_done), .rd_fail(rd_fail), .rd_data(rd_data),
    .launch(launch), .go_read(go_read), .go_phy(go_phy), .go_reg(go_reg),
    .go_data(go_data), .busy(busy), .wr_blocked(wr_blocked), .ctl_word(ctl_word)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .fall_tick(fall_tick), .rise_tick(rise_tick),
    .go(launch), .go_read(go_read), .go_phy(go_phy), .go_reg(go_reg), .go_data(go_data),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .read_turn(read_turn),
    .frame_done(frame_done), .rd_fail(rd_fail), .rd_data(rd_data)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        launch,
  input logic        busy,
  input logic        frame_done,
  input logic        fall_tick,
  input logic        rise_tick,
  input logic        read_turn,
  input logic        mdio_oe,
  input logic        mdio_o,
  input logic        wr_blocked,
  input logic [15:0] ctl_word
);
  // R7
  busy_after_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R7
  busy_clears_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !launch) |=> !busy);

  // R6
  turn_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_turn |-> !mdio_oe);

  // R2
  out_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_tick |=> $stable(mdio_o));

  // R2
  single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_tick, rise_tick}));

  // R9
  blocked_ctl_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> $stable(ctl_word));

  // R9
  no_launch_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .frame_done(frame_done),
  .fall_tick(fall_tick), .rise_tick(rise_tick), .read_turn(read_turn),
  .mdio_oe(mdio_oe), .mdio_o(mdio_o), .wr_blocked(wr_blocked), .ctl_word(ctl_word)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int DIVH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_endian = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mdio_master #(.DIV_HALF(DIVH), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY responder and wire monitor
  logic [63:0] obs = '0;
  int          nbits = 0;
  int          oe_bits = 0;
  int          frames = 0;
  bit          active = 0;
  logic [15:0] resp_data = 16'h0;
  logic        bad_ta = 1'b0;

  always @(posedge mdc) begin
    if (!active && mdio_oe) begin
      active = 1; nbits = 0; oe_bits = 0; obs = '0;
    end
    if (active) begin
      obs = {obs[62:0], mdio_oe ? mdio_o : 1'b0};
      if (mdio_oe) oe_bits++;
      nbits++;
      if (nbits == 64) begin active = 0; frames++; end
    end
    if (active && nbits == 47)                   mdio_i = bad_ta;
    else if (active && nbits >= 48 && nbits < 64) mdio_i = resp_data[63 - nbits];
    else                                          mdio_i = 1'b1;
  end

  function automatic logic [31:0] bsw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = big_endian ? bsw(v) : v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = big_endian ? bsw(bus_rdata) : bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 4000; k++) begin
      rd(8'h30, v);
      if (!v[31]) break;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    logic [31:0] v;
    int f0;
    f0 = frames;
    wr(8'h34, {22'h0, p, r});
    wr(8'h38, {16'h0, d});
    rd(8'h30, v);
    check("R7 busy after data write", v[31], 1'b1);
    wait_idle();
    check("R7 busy held for full write frame", frames, f0 + 1);
    check("R4 write frame bits", obs, {32'hFFFF_FFFF, 4'b0101, p, r, 2'b10, d});
    check("R4 oe high whole frame", oe_bits, 64);
  endtask

  task automatic do_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d,
                         input logic ta_bad);
    logic [31:0] v;
    int f0;
    f0 = frames;
    resp_data = d; bad_ta = ta_bad;
    wr(8'h34, 32'h8000 | {22'h0, p, r});
    rd(8'h30, v);
    check("R7 busy after read launch", v[31], 1'b1);
    check("R8 read error cleared at launch", v[1], 1'b0);
    wait_idle();
    check("R7 busy held for full read frame", frames, f0 + 1);
    check("R5 read header bits", obs[63:18], {32'hFFFF_FFFF, 4'b0110, p, r});
    check("R6 oe released for last 18 bits", oe_bits, 46);
    rd(8'h30, v);
    check("R8 read error flag", v[1], ta_bad);
    if (!ta_bad) begin
      rd(8'h38, v);
      check("R6 captured read data", v, {16'h0, d});
    end
    bad_ta = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    realtime t0, t1;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h30, v); check("R1 cfg reset", v, 0);
    rd(8'h34, v); check("R1 ctl reset", v, 0);
    rd(8'h38, v); check("R1 data reset", v, 0);
    rd(8'h3c, v); check("R1 addr reset", v, 0);
    check("R1 oe reset", mdio_oe, 1'b0);

    // R2 MDC period
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    check("R2 mdc period ns", longint'(t1 - t0), 2 * DIVH * 8);
    @(negedge clk);

    // R10 config and address registers
    wr(8'h30, 32'h0000_0040); rd(8'h30, v); check("R10 c45 bit set", v, 32'h40);
    wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, v); check("R10 only bit 6 writable", v, 32'h40);
    wr(8'h30, 32'h0);         rd(8'h30, v); check("R10 c45 bit clear", v, 0);
    wr(8'h3c, 32'hA5A5_5A5A); rd(8'h3c, v); check("R10 addr storage", v, 32'hA5A5_5A5A);

    // R3 address-only control write
    f0 = frames;
    wr(8'h34, {22'h0, 5'd3, 5'd7});
    rd(8'h30, v); check("R3 no busy", v[31], 1'b0);
    rd(8'h34, v); check("R3 ctl stored", v, {22'h0, 5'd3, 5'd7});
    repeat (300) @(negedge clk);
    check("R3 no frame sent", frames, f0);

    // R4 write sweep and R10 (frame stays clause 22 with c45 bit set)
    wr(8'h30, 32'h40);
    for (int i = 0; i < 8; i++)
      do_write(5'(i * 4 + 1), 5'(31 - i * 3), 16'(i * 16'h1357) ^ 16'hA5C3);
    wr(8'h30, 32'h0);

    // R5 R6 read sweep
    for (int i = 0; i < 8; i++)
      do_read(5'(30 - i * 4), 5'(i * 4 + 2), 16'hC35A ^ 16'(i * 16'h0F1E), 1'b0);

    // R8 error then clean read
    do_read(5'd9, 5'd1, 16'h1234, 1'b1);
    do_read(5'd9, 5'd1, 16'hBEEF, 1'b0);

    // R9 writes during busy ignored
    f0 = frames;
    wr(8'h34, {22'h0, 5'd17, 5'd4});
    wr(8'h38, 32'h0000_6A6A);
    wr(8'h34, 32'h8000 | {22'h0, 5'd2, 5'd2});
    wr(8'h38, 32'h0000_1111);
    rd(8'h34, v); check("R9 ctl unchanged while busy", v, {22'h0, 5'd17, 5'd4});
    rd(8'h38, v); check("R9 data unchanged while busy", v, 32'h6A6A);
    wait_idle();
    check("R9 frame bits intact", obs, {32'hFFFF_FFFF, 4'b0101, 5'd17, 5'd4, 2'b10, 16'h6A6A});
    repeat (400) @(negedge clk);
    check("R9 only one frame sent", frames, f0 + 1);

    // R11 big-endian access
    big_endian = 1'b1;
    do_write(5'd21, 5'd13, 16'h9C3E);
    bus_addr = 8'h38; #1;
    check("R11 raw data read swapped", bus_rdata, bsw(32'h0000_9C3E));
    do_read(5'd6, 5'd27, 16'h4D21, 1'b0);
    wr(8'h30, 32'h40);
    bus_addr = 8'h30; #1;
    check("R11 raw cfg read swapped", bus_rdata, 32'h4000_0000);
    big_endian = 1'b0;
    rd(8'h30, v); check("R11 cfg native order", v, 32'h40);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule